// File: doc/BRIEF.md
# Periodic Flag and Alarm Interrupt Unit

This unit sits beside a time-of-day counter chain and turns its rollover strobes into software-visible events. Each strobe from the counter (the base millisecond tick and the carries out of the 10 ms, 100 ms, 1 s, 10 s and 1 minute stages) latches a sticky periodic flag. The flags stay set until the register holding them is read, and the read clears them. On every base tick the flags are masked by a periodic enable vector. If any enabled flag is set, the periodic source bit of the status register is set.

On the same tick, the six current time fields (seconds, minutes, hours, day, month, day of week) are compared with six compare values. When at least one compare-enable bit is on and any one field equals its compare value, the alarm source bit is set. Both source bits stay set until software writes ones to them. A summary bit is the OR of the remaining sources. It is kept by a two-state controller, IRQ_IDLE and IRQ_ACTIVE. The transition IRQ_IDLE to IRQ_ACTIVE happens when a source becomes set, and it pulls the active-low interrupt pin low. The transition IRQ_ACTIVE to IRQ_IDLE happens when a clear leaves no source set, and it releases the pin.

Top module: `pfa_irq_unit`

## Requirements
- R1: A 1 on `rate_stb[i]` at a clock edge sets `flags_o[i]` after that edge. Bit 0 is the 1 ms tick, bit 1 the 10 ms rollover, bit 2 the 100 ms, bit 3 the 1 s, bit 4 the 10 s and bit 5 the 1 minute rollover. A flag stays set with no further strobe.
- R2: `flag_rd` high at an edge clears every flag after that edge. `flags_o` still shows the pre-clear values during the read cycle.
- R3: If `flag_rd` and a strobe bit are high at the same edge, that flag is set after the edge.
- R4: At an edge where `rate_stb[0]` is 1, `stat_o[0]` (periodic source) is set if `(flags_o | rate_stb) & per_en` is non-zero. It is never set at an edge without `rate_stb[0]`.
- R5: At an edge where `rate_stb[0]` is 1 and `cmp_en` is non-zero, `stat_o[1]` (alarm source) is set if any 8-bit lane `k` of `cur_time` equals lane `k` of `cmp_time`. Lane 0 holds seconds, then minutes, hours, day, month and day of week. When `cmp_en` is zero the alarm is never set.
- R6: `stat_clr` high at an edge clears each status bit whose bit in `stat_clr_mask` is 1 and leaves the others. A source set at the same edge stays set.
- R7: `sum_o` equals the OR of `stat_o` after every edge.
- R8: `int_n` goes low at the edge where the summary rises, goes high at the edge where a clear drops it to 0, and otherwise holds.
- R9: While `rst_n` is low, flags and status are 0, `sum_o` is 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_stb | input | 6 | Tick and rollover strobes, bit 0 = base tick |
| flag_rd | input | 1 | Periodic flag register read strobe |
| per_en | input | 6 | Periodic interrupt enable per flag |
| cmp_en | input | 6 | Alarm compare enables (any bit arms the alarm) |
| cur_time | input | 48 | Current time fields, 8 bits each |
| cmp_time | input | 48 | Compare values, 8 bits each |
| stat_clr | input | 1 | Status write strobe |
| stat_clr_mask | input | 2 | Write-one-to-clear mask, bit 0 periodic, bit 1 alarm |
| flags_o | output | 6 | Sticky periodic flags |
| stat_o | output | 2 | Source bits, bit 0 periodic, bit 1 alarm |
| sum_o | output | 1 | Summary interrupt bit |
| int_n | output | 1 | Active-low interrupt output |

## Verification
The bench aims at four same-edge collisions:
- A flag read on the same edge as a new strobe: a design that lets the read win loses that event.
- A status clear on the same edge as a new source: a design that lets the clear win drops the interrupt.
- A partial clear that leaves one source set: a design that clears the summary on any write releases the pin while a source is still pending.
- Alarm matches with the compare enables at zero, or on edges with no base tick: a design that ignores the gating raises spurious alarms.

A reference model steps through directed sequences and a long run of random traffic. The random traffic uses narrow field values, so that single-field matches occur often.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_ACTIVE
    } irq_state_e;
endpackage

// File: rtl/pfa_flag_bank.sv
module pfa_flag_bank #(
    parameter int NUM_RATE = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_RATE-1:0] rate_stb,
    input  logic                flag_rd,
    input  logic [NUM_RATE-1:0] per_en,
    output logic [NUM_RATE-1:0] flags_q,
    output logic                per_set
);
    logic [NUM_RATE-1:0] merged;

    assign merged  = flags_q | rate_stb;
    assign per_set = rate_stb[0] & (|(merged & per_en));

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flag_rd)
            flags_q <= rate_stb;
        else
            flags_q <= merged;
    end
endmodule

// File: rtl/pfa_alarm_match.sv
module pfa_alarm_match #(
    parameter int NUM_FLD = 6,
    parameter int FLD_W   = 8,
    localparam int BUS_W  = NUM_FLD * FLD_W
) (
    input  logic               tick,
    input  logic [NUM_FLD-1:0] cmp_en,
    input  logic [BUS_W-1:0]   cur_time,
    input  logic [BUS_W-1:0]   cmp_time,
    output logic               alm_set
);
    logic [NUM_FLD-1:0] lane_eq;

    for (genvar k = 0; k < NUM_FLD; k++) begin : g_lane
        assign lane_eq[k] = (cur_time[k*FLD_W +: FLD_W] == cmp_time[k*FLD_W +: FLD_W]);
    end

    assign alm_set = tick & (|cmp_en) & (|lane_eq);
endmodule

// File: rtl/pfa_irq_ctrl.sv
module pfa_irq_ctrl
    import pfa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               stat_clr,
    input  logic [NUM_SRC-1:0] stat_clr_mask,
    output logic [NUM_SRC-1:0] stat_q,
    output logic               sum_o,
    output logic               int_n
);
    irq_state_e          state_q, state_d;
    logic [NUM_SRC-1:0]  stat_d;

    always_comb begin
        stat_d = stat_clr ? (stat_q & ~stat_clr_mask) : stat_q;
        stat_d = stat_d | src_set;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (|stat_d)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!(|stat_d)) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
        end
    end

    always_comb begin
        sum_o = 1'b0;
        int_n = 1'b1;
        unique case (state_q)
            IRQ_IDLE:   begin sum_o = 1'b0; int_n = 1'b1; end
            IRQ_ACTIVE: begin sum_o = 1'b1; int_n = 1'b0; end
            default:    begin sum_o = 1'b0; int_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/pfa_irq_unit.sv
module pfa_irq_unit
    import pfa_pkg::*;
#(
    parameter int NUM_RATE = 6,
    parameter int NUM_FLD  = 6,
    parameter int FLD_W    = 8,
    localparam int BUS_W   = NUM_FLD * FLD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_RATE-1:0] rate_stb,
    input  logic                flag_rd,
    input  logic [NUM_RATE-1:0] per_en,
    input  logic [NUM_FLD-1:0]  cmp_en,
    input  logic [BUS_W-1:0]    cur_time,
    input  logic [BUS_W-1:0]    cmp_time,
    input  logic                stat_clr,
    input  logic [NUM_SRC-1:0]  stat_clr_mask,
    output logic [NUM_RATE-1:0] flags_o,
    output logic [NUM_SRC-1:0]  stat_o,
    output logic                sum_o,
    output logic                int_n
);
    logic               per_set;
    logic               alm_set;
    logic [NUM_SRC-1:0] src_set;

    pfa_flag_bank #(.NUM_RATE(NUM_RATE)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_stb(rate_stb),
        .flag_rd (flag_rd),
        .per_en  (per_en),
        .flags_q (flags_o),
        .per_set (per_set)
    );

    pfa_alarm_match #(.NUM_FLD(NUM_FLD), .FLD_W(FLD_W)) u_alarm (
        .tick    (rate_stb[0]),
        .cmp_en  (cmp_en),
        .cur_time(cur_time),
        .cmp_time(cmp_time),
        .alm_set (alm_set)
    );

    always_comb begin
        src_set          = '0;
        src_set[SRC_PER] = per_set;
        src_set[SRC_ALM] = alm_set;
    end

    pfa_irq_ctrl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_set      (src_set),
        .stat_clr     (stat_clr),
        .stat_clr_mask(stat_clr_mask),
        .stat_q       (stat_o),
        .sum_o        (sum_o),
        .int_n        (int_n)
    );
endmodule

// File: rtl/pfa_irq_checker.sv
module pfa_irq_checker #(
    parameter int NUM_RATE = 6,
    parameter int NUM_SRC  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_RATE-1:0] rate_stb,
    input logic                flag_rd,
    input logic                stat_clr,
    input logic [NUM_SRC-1:0]  stat_clr_mask,
    input logic [NUM_RATE-1:0] flags_o,
    input logic [NUM_SRC-1:0]  stat_o,
    input logic                sum_o,
    input logic                int_n
);
    AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rate_stb) |=> ((flags_o & $past(rate_stb)) == $past(rate_stb))); // R1 R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> ((flags_o & ~$past(rate_stb)) == '0)); // R2

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_stb[0] && !stat_clr) |=> $stable(stat_o)); // R4 R5

    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rate_stb[0]) |=> ((stat_o & $past(stat_clr_mask)) == '0)); // R6

    AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == (|stat_o)); // R7

    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        int_n == !sum_o); // R8

    AST_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_o) |-> $fell(int_n)); // R8
endmodule

bind pfa_irq_unit pfa_irq_checker #(.NUM_RATE(NUM_RATE), .NUM_SRC(pfa_pkg::NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_stb     (rate_stb),
    .flag_rd      (flag_rd),
    .stat_clr     (stat_clr),
    .stat_clr_mask(stat_clr_mask),
    .flags_o      (flags_o),
    .stat_o       (stat_o),
    .sum_o        (sum_o),
    .int_n        (int_n)
);

// File: tb/sim_pfa_irq_unit.sv
`timescale 1ns/1ps
module sim_pfa_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rate_stb = '0;
    logic        flag_rd = 1'b0;
    logic [5:0]  per_en = '0;
    logic [5:0]  cmp_en = '0;
    logic [47:0] cur_time = '0;
    logic [47:0] cmp_time = '0;
    logic        stat_clr = 1'b0;
    logic [1:0]  stat_clr_mask = '0;
    logic [5:0]  flags_o;
    logic [1:0]  stat_o;
    logic        sum_o;
    logic        int_n;

    int checks = 0;
    int failures = 0;
    int m_flags = 0;
    int m_stat = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfa_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .rate_stb(rate_stb), .flag_rd(flag_rd),
        .per_en(per_en), .cmp_en(cmp_en), .cur_time(cur_time), .cmp_time(cmp_time),
        .stat_clr(stat_clr), .stat_clr_mask(stat_clr_mask),
        .flags_o(flags_o), .stat_o(stat_o), .sum_o(sum_o), .int_n(int_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R1/R2/R3 flags", int'(flags_o), m_flags);
        check("R4/R6 periodic status", int'(stat_o[0]), m_stat & 1);
        check("R5/R6 alarm status", int'(stat_o[1]), (m_stat >> 1) & 1);
        check("R7 summary", int'(sum_o), (m_stat != 0) ? 1 : 0);
        check("R8 int_n", int'(int_n), (m_stat != 0) ? 0 : 1);
    endtask

    // One clock: drive, let the edge happen, update the model, compare.
    task automatic step(input logic [5:0] s, input logic r, input logic c, input logic [1:0] cm);
        int merged, per, alm, ns;
        bit anyeq;
        rate_stb = s; flag_rd = r; stat_clr = c; stat_clr_mask = cm;
        merged = m_flags | int'(s);
        per = (s[0] && ((merged & int'(per_en)) != 0)) ? 1 : 0;
        anyeq = 0;
        for (int k = 0; k < 6; k++)
            if (cur_time[k*8 +: 8] == cmp_time[k*8 +: 8]) anyeq = 1;
        alm = (s[0] && cmp_en != 0 && anyeq) ? 1 : 0;
        ns = c ? (m_stat & ~int'(cm)) : m_stat;
        ns = ns | (alm << 1) | per;
        @(posedge clk);
        m_flags = r ? int'(s) : merged;
        m_stat = ns;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 flags", int'(flags_o), 0);
        check("R9 status", int'(stat_o), 0);
        check("R9 summary", int'(sum_o), 0);
        check("R9 int_n", int'(int_n), 1);
        rst_n = 1'b1;

        // R1: each strobe sets its own flag and it sticks
        for (int i = 0; i < 6; i++) step(6'(1 << i), 0, 0, 2'b00);
        step(6'h00, 0, 0, 2'b00);
        // R2: read clears all flags
        step(6'h00, 1, 0, 2'b00);
        // R3: read with a new strobe keeps the strobed flag
        step(6'h08, 0, 0, 2'b00);
        step(6'h01, 1, 0, 2'b00);
        step(6'h00, 0, 0, 2'b00);

        // R4: enabled flag with no tick must not set the source
        per_en = 6'h08;
        step(6'h08, 0, 0, 2'b00);
        step(6'h00, 0, 0, 2'b00);
        // R4 and R8: tick with enabled flag set, summary rises, pin falls
        step(6'h01, 0, 0, 2'b00);
        // R6: writing zeros leaves the source; writing one clears it
        step(6'h00, 0, 1, 2'b10);
        step(6'h00, 1, 1, 2'b01);
        per_en = 6'h00;

        // R5: match with compare disabled gives no alarm
        cur_time = 48'h0706_0504_0302;
        cmp_time = 48'h0706_0504_0302;
        step(6'h01, 0, 0, 2'b00);
        // R5: only the hour lane matches
        cmp_en = 6'h04;
        cmp_time = 48'hFFFF_FF04_FFFF;
        step(6'h01, 0, 0, 2'b00);
        // R5: no lane matches
        cmp_time = 48'hFFFF_FFFF_FFFF;
        step(6'h01, 0, 1, 2'b10);
        // R6/R8: partial clear leaves the other source and the pin low
        per_en = 6'h01;
        cmp_time = 48'h0000_0000_0002;
        step(6'h01, 0, 0, 2'b00);
        step(6'h00, 1, 1, 2'b01);
        // R6: clear and new set at the same edge, set wins
        step(6'h01, 0, 1, 2'b11);
        step(6'h00, 1, 1, 2'b11);

        // Random traffic with narrow fields so matches are frequent
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] s;
            per_en = 6'($urandom);
            cmp_en = ($urandom % 3 == 0) ? 6'h00 : 6'($urandom);
            for (int k = 0; k < 6; k++) begin
                cur_time[k*8 +: 8] = 8'($urandom % 4);
                cmp_time[k*8 +: 8] = 8'($urandom % 4 + 2);
            end
            s = ($urandom % 2 == 0) ? 6'($urandom) : 6'h00;
            step(s, ($urandom % 4) == 0, ($urandom % 3) == 0, 2'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule